// File: doc/BRIEF.md
# UART channel register interface

This block is the register face of one serial channel. A simple synchronous register bus reads and writes a bank of 32-bit registers: line setup, channel control, FIFO setup, modem setup, error and modem status, a baud divisor, and a line status register. Bytes reach the block from a receiver over a valid/ready port. Bytes leave it through a transmit port that uses the same handshake. Serial bit timing belongs to the attached shifter and is not part of this block.

The block implements register-level behaviour only. The receive holding register takes in a byte only while the channel is in interrupt/polling receive mode and the previous byte has been consumed. A bus read of that register marks the byte as consumed. A write to the transmit holding register hands the low byte to the transmitter. Each event can raise a one-cycle sub-interrupt pulse for an interrupt controller, as selected by the mode fields of the control register.

The bus read data is combinational from the current register state. The read side effect on the receive holding register happens at the clock edge on which the read strobe is sampled.

Top module: `uart_reg_if`

## Requirements
- R1: After reset, the status register (offset 0x10) reads 0x6. Every other register reads 0. `rx_ready`, `tx_valid`, `rx_irq` and `tx_irq` are all low.
- R2: `rx_ready` is high only when status bit 0 (receive data ready) is clear and control bits [1:0] (offset 0x04) equal 2'b01. In any other receive mode an offered byte is not taken: status stays unchanged and `rx_irq` stays low.
- R3: A receive handshake (`rx_valid` and `rx_ready` both high on a clock edge) loads the byte into the receive holding register (offset 0x24) and sets status bit 0 and FIFO-status bit 0 (offset 0x18). `rx_irq` is then high for exactly the following cycle.
- R4: A bus read of offset 0x24 returns the held byte in bits [7:0] and clears status bit 0 and FIFO-status bit 0 from the next cycle on.
- R5: While status bit 0 is set, `rx_ready` stays low. A byte offered in that time is held back without overwriting the stored byte, and it is taken in the cycle after software reads offset 0x24.
- R6: A bus write to offset 0x20 sets status bits 1 and 2. From the next cycle, it drives bits [7:0] of the written data on `tx_data` with `tx_valid` high. Both hold steady until a cycle in which `tx_ready` is high, after which `tx_valid` drops.
- R7: `tx_irq` is high for the single cycle after a write to offset 0x20 when control bits [3:2] equal 2'b01 at the time of the write. For any other value of those bits it stays low.
- R8: The line (0x00), control (0x04), FIFO (0x08), modem (0x0C), error (0x14), modem status (0x1C) and divisor (0x28) registers read back the full 32-bit value last written. A write to an unmapped offset or to an address with bits [1:0] nonzero changes nothing, and reads of such addresses return 0.
- R9: Software may write the status register, whose bits [2:0] take the written value and other bits read 0. It may also write the FIFO status register, where only bit 0 is kept. Offset 0x20 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| tx_valid | output | 1 | A byte waits for the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_irq | output | 1 | Receive sub-interrupt pulse |
| tx_irq | output | 1 | Transmit sub-interrupt pulse |

## Verification
The hardest case to reach is a second received byte that arrives while the first is still unread. The second byte must wait, leave the stored byte intact, and then land exactly one cycle after the consuming read. The bench holds `rx_valid` high with a new byte across several cycles, checking that `rx_ready` stays low and the old byte is still readable. It then issues the read of the receive holding register while the offer is still standing, and checks that the new byte appears only afterwards. The mode gating is reached by offering bytes under control values whose mode bits differ from 2'b01.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int WORD_W = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam logic [WORD_W-1:0] W_LINE  = 4'd0;
  localparam logic [WORD_W-1:0] W_CTRL  = 4'd1;
  localparam logic [WORD_W-1:0] W_FIFO  = 4'd2;
  localparam logic [WORD_W-1:0] W_MODEM = 4'd3;
  localparam logic [WORD_W-1:0] W_STAT  = 4'd4;
  localparam logic [WORD_W-1:0] W_ERR   = 4'd5;
  localparam logic [WORD_W-1:0] W_FSTAT = 4'd6;
  localparam logic [WORD_W-1:0] W_MSTAT = 4'd7;
  localparam logic [WORD_W-1:0] W_TXH   = 4'd8;
  localparam logic [WORD_W-1:0] W_RXH   = 4'd9;
  localparam logic [WORD_W-1:0] W_DIV   = 4'd10;

  // plain storage slots
  localparam int N_CFG = 7;
  localparam int S_LINE = 0, S_CTRL = 1, S_FIFO = 2, S_MODEM = 3,
                 S_ERR = 4, S_MSTAT = 5, S_DIV = 6;

  function automatic logic [WORD_W-1:0] slot_word(input int s);
    case (s)
      S_LINE:  return W_LINE;
      S_CTRL:  return W_CTRL;
      S_FIFO:  return W_FIFO;
      S_MODEM: return W_MODEM;
      S_ERR:   return W_ERR;
      S_MSTAT: return W_MSTAT;
      default: return W_DIV;
    endcase
  endfunction

  localparam logic [1:0] MODE_IRQ_POLL = 2'b01;
endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank #(
  parameter int REG_W = 32,
  parameter int N     = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              wr_en,
  input  logic [REG_W-1:0]          wdata,
  output logic [N-1:0][REG_W-1:0]   q
);
  for (genvar s = 0; s < N; s++) begin : g_slot
    logic [REG_W-1:0] d;
    always_comb d = wr_en[s] ? wdata : q[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[s] <= '0;
      else        q[s] <= d;
    end
  end

  // R8: a slot changes only when its own write enable is seen
  p_slot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> (q == $past(q)));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ok,
  input  logic              rd_hold,
  input  logic              sw_wr_stat,
  input  logic              sw_stat_bit,
  input  logic              sw_wr_fstat,
  input  logic              sw_fstat_bit,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] hold_q,
  output logic              rdy_q,
  output logic              frdy_q,
  output logic              rx_irq
);
  logic              take;
  logic [BYTE_W-1:0] hold_d;
  logic              rdy_d, frdy_d;

  assign rx_ready = mode_ok & ~rdy_q;
  assign take     = rx_valid & rx_ready;

  always_comb begin
    hold_d = hold_q;
    rdy_d  = rdy_q;
    frdy_d = frdy_q;
    if (rd_hold) begin
      rdy_d  = 1'b0;
      frdy_d = 1'b0;
    end
    if (sw_wr_stat)  rdy_d  = sw_stat_bit;
    if (sw_wr_fstat) frdy_d = sw_fstat_bit;
    if (take) begin
      hold_d = rx_data;
      rdy_d  = 1'b1;
      frdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      frdy_q <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rdy_q  <= rdy_d;
      frdy_q <= frdy_d;
      rx_irq <= take;
    end
  end

  p_take_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (rdy_q && frdy_q && rx_irq && hold_q == $past(rx_data)));
  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  p_keep_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && rx_valid) |=> $stable(hold_q));
  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold && !sw_wr_stat && !(rx_valid && rx_ready)) |=> !rdy_q);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_thr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              irq_mode_ok,
  input  logic              tx_ready,
  input  logic              sw_wr_stat,
  input  logic [1:0]        sw_stat_bits,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  output logic [1:0]        st_q,
  output logic              tx_irq
);
  logic [BYTE_W-1:0] data_d;
  logic              valid_d;
  logic [1:0]        st_d;

  always_comb begin
    data_d  = tx_data;
    valid_d = tx_valid;
    st_d    = st_q;
    if (tx_valid && tx_ready) valid_d = 1'b0;
    if (sw_wr_stat) st_d = sw_stat_bits;
    if (wr_thr) begin
      data_d  = wr_byte;
      valid_d = 1'b1;
      st_d    = 2'b11;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      st_q     <= 2'b11;
      tx_irq   <= 1'b0;
    end else begin
      tx_data  <= data_d;
      tx_valid <= valid_d;
      st_q     <= st_d;
      tx_irq   <= wr_thr & irq_mode_ok;
    end
  end

  p_thr_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> (st_q == 2'b11 && tx_valid && tx_data == $past(wr_byte)));
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_thr) |=> (tx_valid && $stable(tx_data)));
  p_tx_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(wr_thr));
endmodule

// File: rtl/uart_reg_if.sv
module uart_reg_if
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic                          rst_n_i;
  logic                          aligned;
  logic [WORD_W-1:0]             word;
  logic [N_CFG-1:0]              cfg_wr;
  logic [N_CFG-1:0][REG_W-1:0]   cfg_q;
  logic                          wr_stat, wr_fstat, wr_thr, rd_rxh;
  logic [BYTE_W-1:0]             rx_hold;
  logic                          rx_rdy, rx_frdy;
  logic [1:0]                    tx_st;
  logic [REG_W-1:0]              ctrl;

  uart_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];

  for (genvar s = 0; s < N_CFG; s++) begin : g_dec
    assign cfg_wr[s] = bus_wr & aligned & (word == slot_word(s));
  end

  assign wr_stat  = bus_wr & aligned & (word == W_STAT);
  assign wr_fstat = bus_wr & aligned & (word == W_FSTAT);
  assign wr_thr   = bus_wr & aligned & (word == W_TXH);
  assign rd_rxh   = bus_rd & aligned & (word == W_RXH);
  assign ctrl     = cfg_q[S_CTRL];

  uart_cfg_bank #(.REG_W(REG_W), .N(N_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .wr_en(cfg_wr), .wdata(bus_wdata), .q(cfg_q)
  );

  uart_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n_i),
    .mode_ok(ctrl[1:0] == MODE_IRQ_POLL),
    .rd_hold(rd_rxh),
    .sw_wr_stat(wr_stat), .sw_stat_bit(bus_wdata[0]),
    .sw_wr_fstat(wr_fstat), .sw_fstat_bit(bus_wdata[0]),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .hold_q(rx_hold), .rdy_q(rx_rdy), .frdy_q(rx_frdy), .rx_irq(rx_irq)
  );

  uart_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n_i),
    .wr_thr(wr_thr), .wr_byte(bus_wdata[BYTE_W-1:0]),
    .irq_mode_ok(ctrl[3:2] == MODE_IRQ_POLL),
    .tx_ready(tx_ready),
    .sw_wr_stat(wr_stat), .sw_stat_bits(bus_wdata[2:1]),
    .tx_data(tx_data), .tx_valid(tx_valid), .st_q(tx_st), .tx_irq(tx_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        W_LINE:  bus_rdata = cfg_q[S_LINE];
        W_CTRL:  bus_rdata = cfg_q[S_CTRL];
        W_FIFO:  bus_rdata = cfg_q[S_FIFO];
        W_MODEM: bus_rdata = cfg_q[S_MODEM];
        W_ERR:   bus_rdata = cfg_q[S_ERR];
        W_MSTAT: bus_rdata = cfg_q[S_MSTAT];
        W_DIV:   bus_rdata = cfg_q[S_DIV];
        W_STAT:  bus_rdata = {{(REG_W-3){1'b0}}, tx_st, rx_rdy};
        W_FSTAT: bus_rdata = {{(REG_W-1){1'b0}}, rx_frdy};
        W_RXH:   bus_rdata = {{(REG_W-BYTE_W){1'b0}}, rx_hold};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: no byte is taken outside receive mode 01
  p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ctrl[1:0] != MODE_IRQ_POLL) |-> !rx_ready);
  // R7: no transmit pulse unless the mode selected it on the write
  p_tx_irq_mode_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    tx_irq |-> ($past(ctrl[3:2]) == MODE_IRQ_POLL));
endmodule

// File: tb/sim_uart_reg_if.sv
module sim_uart_reg_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid, rx_ready, tx_valid, tx_ready, rx_irq, tx_irq;
  logic [7:0]  rx_data, tx_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_reg_if u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    bus_read(a, d);
    chk(d == e, req, d, e);
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 'h28; a += 4)
      expect_reg(a[5:0], (a == 'h10) ? 32'h6 : 32'h0, "R1 reset value");
    chk(!rx_ready && !tx_valid && !rx_irq && !tx_irq, "R1 outputs idle",
        {rx_ready, tx_valid, rx_irq, tx_irq}, 0);
  endtask

  task automatic t_cfg;
    logic [5:0] offs [7] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h14, 6'h1C, 6'h28};
    foreach (offs[i]) bus_write(offs[i], 32'hA000_0000 + i * 32'h111 + 32'h2);
    bus_write(6'h2C, 32'hFFFF_FFFF);
    bus_write(6'h05, 32'hFFFF_FFFF);
    foreach (offs[i]) expect_reg(offs[i], 32'hA000_0000 + i * 32'h111 + 32'h2, "R8 readback");
    expect_reg(6'h2C, 0, "R8 unmapped read");
    expect_reg(6'h05, 0, "R8 misaligned read");
  endtask

  task automatic t_mode_gate;
    bus_write(6'h04, 32'h0);
    @(negedge clk); rx_valid = 1; rx_data = 8'h11; #1
    chk(!rx_ready, "R2 ready low mode 00", rx_ready, 0);
    bus_write(6'h04, 32'h2);
    #1 chk(!rx_ready, "R2 ready low mode 10", rx_ready, 0);
    chk(!rx_irq, "R2 no irq", rx_irq, 0);
    rx_valid = 0;
    expect_reg(6'h10, 32'h6, "R2 status unchanged");
    expect_reg(6'h24, 32'h0, "R2 holding unchanged");
  endtask

  task automatic t_rx_accept;
    bus_write(6'h04, 32'h1);
    @(negedge clk); rx_valid = 1; rx_data = 8'hA5; #1
    chk(rx_ready, "R2 ready high mode 01", rx_ready, 1);
    @(negedge clk); rx_valid = 0;
    chk(rx_irq, "R3 rx irq pulse", rx_irq, 1);
    @(negedge clk);
    chk(!rx_irq, "R3 rx irq single cycle", rx_irq, 0);
    expect_reg(6'h10, 32'h7, "R3 status bit0 set");
    expect_reg(6'h18, 32'h1, "R3 fifo status bit0 set");
  endtask

  task automatic t_rx_backpressure;
    logic [31:0] d;
    @(negedge clk); rx_valid = 1; rx_data = 8'h3C;
    repeat (3) begin
      #1 chk(!rx_ready, "R5 ready low while full", rx_ready, 0);
      @(negedge clk);
    end
    chk(!rx_irq, "R5 no irq while full", rx_irq, 0);
    // consuming read with offer still standing
    bus_rd = 1; bus_addr = 6'h24; #1 d = bus_rdata;
    chk(d == 32'hA5, "R4 read returns byte", d, 32'hA5);
    chk(!rx_ready, "R5 ready low during read", rx_ready, 0);
    @(negedge clk); bus_rd = 0; #1
    chk(rx_ready, "R5 ready after read", rx_ready, 1);
    @(negedge clk); rx_valid = 0;
    chk(rx_irq, "R5 held byte taken", rx_irq, 1);
    expect_reg(6'h24, 32'h3C, "R5 new byte stored");
    expect_reg(6'h10, 32'h6, "R4 status bit0 cleared");
    expect_reg(6'h18, 32'h0, "R4 fifo bit0 cleared");
  endtask

  task automatic t_tx;
    bus_write(6'h10, 32'h0);
    expect_reg(6'h10, 32'h0, "R9 status written zero");
    bus_write(6'h04, 32'h1);
    bus_write(6'h20, 32'h1234);
    chk(!tx_irq, "R7 no irq mode 00", tx_irq, 0);
    chk(tx_valid && tx_data == 8'h34, "R6 tx byte", {tx_valid, tx_data}, 9'h134);
    expect_reg(6'h10, 32'h6, "R6 status bits 1,2 set");
    expect_reg(6'h20, 32'h0, "R9 tx holding reads zero");
    chk(tx_valid && tx_data == 8'h34, "R6 tx held", {tx_valid, tx_data}, 9'h134);
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk(!tx_valid, "R6 tx consumed", tx_valid, 0);
    bus_write(6'h04, 32'h5);
    bus_write(6'h20, 32'h5A);
    chk(tx_irq, "R7 irq mode 01", tx_irq, 1);
    @(negedge clk);
    chk(!tx_irq, "R7 irq single cycle", tx_irq, 0);
    bus_write(6'h04, 32'h9);
    bus_write(6'h20, 32'h77);
    chk(!tx_irq, "R7 no irq mode 10", tx_irq, 0);
    chk(tx_data == 8'h77, "R6 overwrite byte", tx_data, 8'h77);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  task automatic t_sw_status;
    bus_write(6'h10, 32'hFFFF_FFFF);
    expect_reg(6'h10, 32'h7, "R9 status bits 2:0");
    chk(!rx_ready, "R9 status bit0 blocks rx", rx_ready, 0);
    bus_write(6'h18, 32'hFF);
    expect_reg(6'h18, 32'h1, "R9 fifo status bit0 only");
    bus_write(6'h10, 32'h0);
    expect_reg(6'h10, 32'h0, "R9 status cleared");
  endtask

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_cfg;
    t_mode_gate;
    t_rx_accept;
    t_rx_backpressure;
    t_tx;
    t_sw_status;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule